// File: doc/BRIEF.md
# Processor Trace Compressor and Buffer

This block takes a stream of per-cycle trace events from a processor and packs it into a compact history held on chip. Each event is either a status code or a data item. A data item is a byte read, a byte written, or a 16-bit branch target that is already halved. Consecutive sequential-instruction codes are folded into one run-count entry. Data items are split into tagged 4-bit nibble entries. Every stored entry is 6 bits wide and goes into a 64-entry circular buffer.

An event can produce up to five entries: a flushed run count followed by four address nibbles. All of them are written in the cycle the event arrives, so the event input never stalls. A debug host raises the freeze input to stop capture. It then walks the buffer through a registered read port, starting from the reported oldest location and reading as many entries as the valid count shows.

Top module: `trace_compressor`

## Requirements
- R1: After reset the valid count and the oldest-entry pointer are 0, and every buffer location reads back as 0.
- R2: A run of exactly one sequential status (code 0x01) is stored as the single entry 0x01 when a non-sequential event ends it.
- R3: A run of N sequential statuses, with 2 <= N <= 14, is stored as the entry 0x10+N ahead of the event that ends it, and the run counter clears.
- R4: When a run reaches 15 it is written at once as 0x1F and counting restarts from zero. For example, 17 sequential statuses followed by a branch are stored as 0x1F, 0x12, 0x05.
- R5: Every status code other than 0x01 (kind 0) is stored unchanged as one entry, in arrival order.
- R6: A read-byte event (kind 1) stores 0x20|low nibble and then 0x20|high nibble. A write-byte event (kind 2) stores 0x30|low nibble and then 0x30|high nibble.
- R7: A target event (kind 3) stores four entries 0x20|nibble, least significant nibble first.
- R8: A pending run count is flushed ahead of data entries just as it is ahead of status entries.
- R9: Entries go to consecutive locations modulo 64. The valid count saturates at 64. The oldest pointer is 0 until the buffer is full and equals the next write location afterwards.
- R10: While freeze is high, incoming events are ignored. No entry is written and the pending run count is kept, so it is flushed normally after freeze drops.
- R11: Read data reflects the read address applied one clock edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_valid_i | input | 1 | An event is presented this cycle |
| ev_kind_i | input | 2 | 0 status, 1 read byte, 2 write byte, 3 target |
| ev_code_i | input | 6 | Status code for kind 0 |
| ev_data_i | input | 16 | Byte in bits 7:0, or the halved target address |
| freeze_i | input | 1 | Stop capturing events |
| rd_addr_i | input | 6 | Buffer location to read |
| rd_data_o | output | 6 | Entry at the location applied one cycle earlier |
| oldest_o | output | 6 | Location of the oldest valid entry |
| count_o | output | 7 | Number of valid entries, 0 to 64 |

## Verification
The bench sweeps every run length from 1 to 31 and checks both edges of the compression rule. An off-by-one in the flush would emit 0x11 for a single instruction, and a late saturation would overflow into 0x20 and collide with the data tags. Every status code and every byte value in both directions is pushed through, which exposes swapped nibble order or swapped read/write tags. The buffer wraps many times during the run, so a pointer that fails to wrap, or a count that keeps growing past 64, shows up as a wrong oldest location or as stale readback. Freezing the block in the middle of a run catches a design that writes while frozen or drops its pending count, and a read-address change sampled just before the edge catches a combinational read path.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int ENTRY_W = 6;
  typedef logic [ENTRY_W-1:0] entry_t;

  typedef enum logic [1:0] {
    EV_STAT   = 2'd0,
    EV_RDATA  = 2'd1,
    EV_WDATA  = 2'd2,
    EV_TARGET = 2'd3
  } ev_kind_e;

  localparam entry_t ST_SEQ  = 6'h01;
  localparam entry_t TAG_RUN = 6'h10;
  localparam entry_t TAG_RD  = 6'h20;
  localparam entry_t TAG_WR  = 6'h30;
endpackage

// File: rtl/trc_encoder.sv
module trc_encoder
  import trc_pkg::*;
#(
  parameter int RUN_MAX  = 15,
  parameter int ADDR_NIB = 4,
  parameter int LANES    = ADDR_NIB + 1,
  parameter int CNT_W    = $clog2(LANES + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       fire_i,
  input  logic [1:0]                 kind_i,
  input  entry_t                     code_i,
  input  logic [4*ADDR_NIB-1:0]      data_i,
  output logic [LANES-1:0][ENTRY_W-1:0] lanes_o,
  output logic [CNT_W-1:0]           n_o
);
  localparam int RUN_W = $clog2(RUN_MAX);

  logic [RUN_W-1:0] run_q, run_d;
  ev_kind_e kind;
  logic     is_seq;

  assign kind   = ev_kind_e'(kind_i);
  assign is_seq = (kind == EV_STAT) && (code_i == ST_SEQ);

  always_comb begin
    lanes_o = '0;
    n_o     = '0;
    run_d   = run_q;
    if (fire_i) begin
      if (is_seq) begin
        if (run_q == RUN_W'(RUN_MAX - 1)) begin
          lanes_o[0] = TAG_RUN | ENTRY_W'(RUN_MAX);
          n_o        = CNT_W'(1);
          run_d      = '0;
        end else begin
          run_d = run_q + RUN_W'(1);
        end
      end else begin
        // flush pending run ahead of anything else
        if (run_q != '0) begin
          lanes_o[0] = (run_q == RUN_W'(1)) ? ST_SEQ : (TAG_RUN | ENTRY_W'(run_q));
          n_o        = CNT_W'(1);
        end
        run_d = '0;
        unique case (kind)
          EV_STAT: begin
            lanes_o[n_o] = code_i;
            n_o          = n_o + CNT_W'(1);
          end
          EV_RDATA, EV_WDATA: begin
            for (int k = 0; k < 2; k++) begin
              lanes_o[n_o] = ((kind == EV_RDATA) ? TAG_RD : TAG_WR) | {2'b00, data_i[4*k +: 4]};
              n_o          = n_o + CNT_W'(1);
            end
          end
          EV_TARGET: begin
            for (int k = 0; k < ADDR_NIB; k++) begin
              lanes_o[n_o] = TAG_RD | {2'b00, data_i[4*k +: 4]};
              n_o          = n_o + CNT_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else         run_q <= run_d;
  end

  a_r4_run_below_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q < RUN_W'(RUN_MAX));

  a_r3_run_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && !is_seq) |=> (run_q == '0));

  a_r2_single_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && !is_seq && run_q == RUN_W'(1)) |-> (lanes_o[0] == ST_SEQ && n_o >= CNT_W'(2)));

  a_r10_idle_holds_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> $stable(run_q));

  a_r8_lane_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_o <= CNT_W'(LANES));
endmodule

// File: rtl/trc_buffer.sv
module trc_buffer
  import trc_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LANES = 5,
  parameter int CNT_W = $clog2(LANES + 1),
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [LANES-1:0][ENTRY_W-1:0] lanes_i,
  input  logic [CNT_W-1:0]              n_i,
  input  logic [AW-1:0]                 rd_addr_i,
  output entry_t                        rd_data_o,
  output logic [AW-1:0]                 oldest_o,
  output logic [AW:0]                   count_o
);
  localparam int LW = $clog2(LANES);

  entry_t          mem_q [DEPTH];
  logic [AW-1:0]   wr_ptr_q;
  logic [AW:0]     count_q, sum;
  entry_t          rd_q;

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic [AW-1:0] off;
    assign off = AW'(e) - wr_ptr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                mem_q[e] <= '0;
      else if (off < AW'(n_i))    mem_q[e] <= lanes_i[off[LW-1:0]];
    end
  end

  assign sum = count_q + (AW+1)'(n_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      count_q  <= '0;
      rd_q     <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_q + AW'(n_i);
      count_q  <= (sum > (AW+1)'(DEPTH)) ? (AW+1)'(DEPTH) : sum;
      rd_q     <= mem_q[rd_addr_i];
    end
  end

  assign rd_data_o = rd_q;
  assign count_o   = count_q;
  assign oldest_o  = (count_q == (AW+1)'(DEPTH)) ? wr_ptr_q : '0;

  a_r9_count_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= (AW+1)'(DEPTH));

  a_r9_full_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == (AW+1)'(DEPTH)) |=> (count_q == (AW+1)'(DEPTH)));

  a_r9_ptr_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_i == '0) |=> $stable(wr_ptr_q));

  a_r9_count_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_i != '0 && count_q < (AW+1)'(DEPTH)) |=> (count_q > $past(count_q)));
endmodule

// File: rtl/trace_compressor.sv
module trace_compressor
  import trc_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int ADDR_NIB = 4,
  parameter int RUN_MAX  = 15,
  localparam int AW      = $clog2(DEPTH),
  localparam int LANES   = ADDR_NIB + 1,
  localparam int CNT_W   = $clog2(LANES + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ev_valid_i,
  input  logic [1:0]            ev_kind_i,
  input  logic [ENTRY_W-1:0]    ev_code_i,
  input  logic [4*ADDR_NIB-1:0] ev_data_i,
  input  logic                  freeze_i,
  input  logic [AW-1:0]         rd_addr_i,
  output logic [ENTRY_W-1:0]    rd_data_o,
  output logic [AW-1:0]         oldest_o,
  output logic [AW:0]           count_o
);
  logic                          fire;
  logic [LANES-1:0][ENTRY_W-1:0] lanes;
  logic [CNT_W-1:0]              n_wr;

  assign fire = ev_valid_i && !freeze_i;

  trc_encoder #(
    .RUN_MAX (RUN_MAX),
    .ADDR_NIB(ADDR_NIB),
    .LANES   (LANES),
    .CNT_W   (CNT_W)
  ) u_enc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .kind_i (ev_kind_i),
    .code_i (ev_code_i),
    .data_i (ev_data_i),
    .lanes_o(lanes),
    .n_o    (n_wr)
  );

  trc_buffer #(
    .DEPTH(DEPTH),
    .LANES(LANES),
    .CNT_W(CNT_W),
    .AW   (AW)
  ) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lanes_i  (lanes),
    .n_i      (n_wr),
    .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o),
    .oldest_o (oldest_o),
    .count_o  (count_o)
  );

  a_r10_freeze_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> ($stable(count_o) && $stable(oldest_o)));

  a_r10_no_write_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |-> (n_wr == '0));
endmodule

// File: tb/trace_compressor_bench.sv
`timescale 1ns/1ps
module trace_compressor_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic [1:0]  ev_kind = '0;
  logic [5:0]  ev_code = '0;
  logic [15:0] ev_data = '0;
  logic        freeze = 1'b0;
  logic [5:0]  rd_addr = '0;
  logic [5:0]  rd_data;
  logic [5:0]  oldest;
  logic [6:0]  count;

  int checks = 0;
  int errors = 0;
  int em [64];
  int ewp = 0, ecnt = 0, erun = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trace_compressor u_trace_compressor (
    .clk_i(clk), .rst_ni(rst_n), .ev_valid_i(ev_valid), .ev_kind_i(ev_kind),
    .ev_code_i(ev_code), .ev_data_i(ev_data), .freeze_i(freeze),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .oldest_o(oldest), .count_o(count)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic void push(int v);
    em[ewp] = v;
    ewp = (ewp + 1) % 64;
    if (ecnt < 64) ecnt++;
  endfunction

  function automatic void model(int kind, int code, int data);
    if (kind == 0 && code == 1) begin
      if (erun == 14) begin push(8'h1F); erun = 0; end
      else erun++;
    end else begin
      if (erun == 1) push(1);
      else if (erun > 1) push(16 + erun);
      erun = 0;
      case (kind)
        0: push(code);
        1: begin push(32 + (data & 15)); push(32 + ((data >> 4) & 15)); end
        2: begin push(48 + (data & 15)); push(48 + ((data >> 4) & 15)); end
        default: for (int k = 0; k < 4; k++) push(32 + ((data >> (4*k)) & 15));
      endcase
    end
  endfunction

  task automatic ev(int kind, int code, int data);
    @(negedge clk);
    ev_valid = 1'b1;
    ev_kind  = 2'(kind);
    ev_code  = 6'(code);
    ev_data  = 16'(data);
    if (!freeze) model(kind, code, data);
    @(posedge clk);
    #1 ev_valid = 1'b0;
  endtask

  task automatic seq(int n);
    for (int i = 0; i < n; i++) ev(0, 1, 0);
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    rd_addr = 6'(a);
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic check_buf(string req);
    int v, eo;
    @(negedge clk);
    eo = (ecnt == 64) ? ewp : 0;
    chk("R9 count", int'(count), ecnt);
    chk("R9 oldest", int'(oldest), eo);
    for (int i = 0; i < ecnt; i++) begin
      rd((eo + i) % 64, v);
      chk(req, v, em[(eo + i) % 64]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, a, b;
    for (int i = 0; i < 64; i++) em[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 count", int'(count), 0);
    chk("R1 oldest", int'(oldest), 0);
    for (int i = 0; i < 64; i += 9) begin rd(i, v); chk("R1 mem", v, 0); end

    // R2 single sequential
    seq(1); ev(0, 5, 0);
    check_buf("R2");

    // R3 runs 2..14
    for (int n = 2; n <= 14; n++) begin seq(n); ev(0, 5, 0); end
    check_buf("R3");

    // R4 saturating runs
    for (int n = 15; n <= 31; n++) begin seq(n); ev(0, 5, 0); end
    check_buf("R4");

    // R5 all non-sequential codes
    for (int c = 0; c < 64; c++) if (c != 1) ev(0, c, 0);
    check_buf("R5");

    // R6 every byte read and written
    for (int bb = 0; bb < 256; bb++) begin
      ev(0, 8, 0); ev(1, 0, bb); ev(0, 8, 0); ev(2, 0, bb);
      if (bb % 16 == 15) check_buf("R6");
    end

    // R7 targets, exception and return frames
    for (int k = 0; k < 16; k++) ev(3, 0, 1 << k);
    check_buf("R7");
    ev(0, 8'h1C, 0); ev(0, 8'h1C, 0); ev(0, 5, 0); ev(0, 8'h0D, 0); ev(3, 0, 16'h083A);
    seq(9); ev(0, 8, 0); ev(2, 0, 8'h00);
    ev(0, 7, 0); ev(0, 3, 0); ev(0, 5, 0); ev(0, 8'h0D, 0); ev(3, 0, 16'h2A19);
    check_buf("R7");

    // R8 flush ahead of data
    seq(3); ev(1, 0, 8'h5A); seq(1); ev(3, 0, 16'hBEEF); seq(6); ev(2, 0, 8'hC3);
    check_buf("R8");

    // R10 freeze keeps run and buffer
    seq(3);
    @(negedge clk); freeze = 1'b1;
    ev(0, 5, 0); ev(1, 0, 8'h77); ev(3, 0, 16'h1234); seq(5);
    check_buf("R10");
    @(negedge clk); freeze = 1'b0;
    ev(0, 5, 0);
    check_buf("R10");

    // R11 one-cycle read latency
    a = (ewp + 63) % 64;
    b = a;
    for (int i = 0; i < 64; i++) if (em[i] != em[a]) b = i;
    rd(a, v);
    chk("R11 first", v, em[a]);
    @(negedge clk);
    rd_addr = 6'(b);
    #1 chk("R11 before edge", int'(rd_data), em[a]);
    @(negedge clk);
    chk("R11 after edge", int'(rd_data), em[b]);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule